// File: doc/BRIEF.md
# I2C Bus Clock and Data Strobe Timer

This block produces the serial clock of an I2C controller from the core clock. It also produces two single-cycle strobes that tell the neighbouring shift logic when to act. The period is set by a 16-bit divider word whose lowest bit is dropped, so the clock is always high for exactly half the period and low for the other half. One strobe marks the cycle in which the shifter should put the next bit on the data line. It follows each falling clock edge by a programmable number of core cycles. The other strobe marks the cycle in which the shifter should capture the incoming data line. It follows each rising clock edge by a second programmable number of cycles.

Both delays arrive in one 32-bit word. The launch delay sits in the upper half, and the capture delay sits in the lower half. An enable input starts and stops the clock. While idle the clock rests high. A run always begins with a full high phase. A stop is taken only at the end of a high phase, so the line is never left low and no phase is cut short. Register access and byte framing belong to other blocks.

Top module: `i2c_scl_timing`

## Requirements
- R1: While running, SCL is high for H core cycles and then low for H core cycles, where H is the divider word shifted right by one (period 2·H).
- R2: Bit 0 of the divider word has no effect: a divider of 5 gives exactly the timing of a divider of 4.
- R3: A divider word of 0 or 1 selects the largest half period, H = 32768 (period 65536 cycles).
- R4: `launch_stb` is high for one cycle exactly D_f cycles after the cycle in which SCL first reads low, where D_f is the launch delay; D_f = 0 puts the strobe in that same cycle.
- R5: `sample_stb` is high for one cycle exactly D_r cycles after the cycle in which SCL first reads high after a low phase, where D_r is the capture delay.
- R6: A delay larger than H acts as H, so its strobe lands in the same cycle as the next opposite SCL edge.
- R7: In `dly_cfg`, bits 31:16 hold the launch (after-falling) delay and bits 15:0 hold the capture (after-rising) delay.
- R8: After reset SCL is high and both strobes are low; when `enable` is first seen high, SCL stays high for H more cycles and then falls.
- R9: SCL falls only if `enable` is high at the end of a high phase; otherwise it stays high, and no further edges or strobes occur apart from a strobe still owed to the last edge.
- R10: The smallest legal divider, 2, gives H = 1, so SCL changes level every core cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run request for the bus clock |
| div_val | input | 16 | Period in core cycles; bit 0 ignored |
| dly_cfg | input | 32 | Launch delay [31:16], capture delay [15:0] |
| scl_o | output | 1 | Bus clock level |
| launch_stb | output | 1 | Drive-next-bit strobe |
| sample_stb | output | 1 | Capture-data strobe |

## Verification
The capture strobe owed to a rising edge and the launch strobe of the following falling edge can fire in the same cycle as that falling edge. This happens when the capture delay is clamped to or equal to H and the launch delay is zero. One run sets a divider of 20, a launch delay of 0 and a capture delay of 10 to force this case. Another run uses the minimum divider, where every strobe lands on an SCL edge. The scoreboard orders expected events by cycle and then by kind (fall, rise, launch, capture), so a strobe that is lost, doubled or shifted by one cycle in such a coinciding cycle appears as a mismatch against the queue head.

// File: rtl/i2c_scl_pkg.sv
// Shared constants and types for the I2C bus clock timer.
// Assumes: strobe channel 0 follows falling edges, channel 1 follows rising edges.
package i2c_scl_pkg;

    localparam int STB_LAUNCH = 0;  // strobe after the SCL falling edge
    localparam int STB_SAMPLE = 1;  // strobe after the SCL rising edge
    localparam int NUM_STB    = 2;

    typedef enum logic {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

endpackage

// File: rtl/scl_cfg_decode.sv
// Turns the raw divider and delay words into the half period and two clamped delays.
// Assumes: divider bit 0 is ignored; a zero half period means the largest one;
// the upper half of dly_cfg is the launch delay and the lower half is the capture delay.
module scl_cfg_decode
    import i2c_scl_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0]        div_val,
    input  logic [2*CW-1:0]      dly_cfg,
    output logic [CW-1:0]        half_per,
    output logic [NUM_STB-1:0][CW-1:0] dly_eff
);

    localparam logic [CW-1:0] HALF_MAX = {1'b1, {(CW-1){1'b0}}};

    // Half period: drop bit 0, map zero onto the largest value.
    always_comb begin
        if (div_val[CW-1:1] == '0) begin
            half_per = HALF_MAX;
        end else begin
            half_per = {1'b0, div_val[CW-1:1]};
        end
    end

    // One clamp per strobe channel: a delay never exceeds the half period.
    for (genvar g = 0; g < NUM_STB; g++) begin : g_clamp
        localparam int BASE = (g == STB_LAUNCH) ? CW : 0;
        logic [CW-1:0] raw;
        assign raw        = dly_cfg[BASE +: CW];
        assign dly_eff[g] = (raw > half_per) ? half_per : raw;
    end

endmodule

// File: rtl/scl_phase_gen.sv
// Produces the SCL level and one-cycle markers for its falling and rising edges.
// Assumes: half_per >= 1. Idle level is high. A run opens with a full high phase,
// and a stop is taken only at the end of a high phase.
module scl_phase_gen
    import i2c_scl_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] half_per,
    output logic          scl,
    output logic          fall_evt,
    output logic          rise_evt
);

    run_state_e    state;
    logic [CW-1:0] cnt;
    logic          term;

    // End of the current half phase; >= keeps a shrunk setting from stalling.
    assign term = (cnt >= half_per - 1'b1);

    // Phase counter, SCL level and edge markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RUN_IDLE;
            cnt      <= '0;
            scl      <= 1'b1;
            fall_evt <= 1'b0;
            rise_evt <= 1'b0;
        end else begin
            fall_evt <= 1'b0;
            rise_evt <= 1'b0;
            case (state)
                RUN_IDLE: begin
                    scl <= 1'b1;
                    cnt <= '0;
                    if (enable) begin
                        state <= RUN_ACTIVE;
                    end
                end
                default: begin
                    if (term) begin
                        cnt <= '0;
                        if (scl) begin
                            if (enable) begin
                                scl      <= 1'b0;
                                fall_evt <= 1'b1;
                            end else begin
                                state <= RUN_IDLE;
                            end
                        end else begin
                            scl      <= 1'b1;
                            rise_evt <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R8: the line rests high whenever the generator is idle.
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RUN_IDLE) |-> scl);

    // R9: a falling edge needs enable seen high at the end of the high phase.
    assert_fall_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |-> $past(enable));

    // R1: the level holds until the phase counter ends the half period.
    assert_half_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RUN_ACTIVE && !term) |=> $stable(scl));

    // R1: every level change is flagged as the matching edge marker.
    assert_edge_marked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (scl != $past(scl)) |-> (scl ? rise_evt : fall_evt));

endmodule

// File: rtl/scl_strobe_timer.sv
// Emits a one-cycle strobe a programmed number of cycles after an edge marker.
// Assumes: the delay is no larger than the gap to the next marker, so a pending
// strobe fires no later than the cycle in which the next marker reloads the timer.
module scl_strobe_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_evt,
    input  logic [CW-1:0] dly,
    output logic          stb
);

    logic          armed;
    logic [CW-1:0] left;

    // Fire at the end of a countdown, or at once for a zero delay.
    assign stb = (armed && (left == '0)) || (edge_evt && (dly == '0));

    // Countdown: load on a marker, count to zero, then disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (edge_evt && (dly != '0)) begin
            armed <= 1'b1;
            left  <= dly - 1'b1;
        end else if (armed) begin
            if (left == '0) begin
                armed <= 1'b0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    // R4: an armed countdown drops by one each cycle without a new marker.
    assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (left != '0) && !edge_evt) |=> (armed && (left == $past(left) - 1'b1)));

    // R5: after firing without a reload the timer goes quiet.
    assert_fire_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (left == '0) && !edge_evt) |=> !armed);

endmodule

// File: rtl/i2c_scl_timing.sv
// I2C bus clock generator with launch and capture strobes.
// Assumes: div_val and dly_cfg are held steady while enable is high.
module i2c_scl_timing
    import i2c_scl_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0]   div_val,
    input  logic [2*CW-1:0] dly_cfg,
    output logic          scl_o,
    output logic          launch_stb,
    output logic          sample_stb
);

    logic [CW-1:0]              half_per;
    logic [NUM_STB-1:0][CW-1:0] dly_eff;
    logic                       fall_evt;
    logic                       rise_evt;
    logic [NUM_STB-1:0]         edge_evt;
    logic [NUM_STB-1:0]         stb_vec;

    scl_cfg_decode #(.CW(CW)) u_decode (
        .div_val  (div_val),
        .dly_cfg  (dly_cfg),
        .half_per (half_per),
        .dly_eff  (dly_eff)
    );

    scl_phase_gen #(.CW(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .half_per (half_per),
        .scl      (scl_o),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt)
    );

    assign edge_evt[STB_LAUNCH] = fall_evt;
    assign edge_evt[STB_SAMPLE] = rise_evt;

    for (genvar g = 0; g < NUM_STB; g++) begin : g_timer
        scl_strobe_timer #(.CW(CW)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .edge_evt (edge_evt[g]),
            .dly      (dly_eff[g]),
            .stb      (stb_vec[g])
        );
    end

    assign launch_stb = stb_vec[STB_LAUNCH];
    assign sample_stb = stb_vec[STB_SAMPLE];

endmodule

// File: tb/i2c_scl_timing_tb_top.sv
// Scoreboard bench: the driver predicts every edge and strobe cycle, and the monitor compares.
module i2c_scl_timing_tb_top;

    localparam int CW = 16;
    localparam int K_FALL = 0, K_RISE = 1, K_LAUNCH = 2, K_SAMPLE = 3;

    typedef struct {
        int cyc;
        int kind;
    } ev_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic [CW-1:0]   div_val = 16'd8;
    logic [2*CW-1:0] dly_cfg = '0;
    logic            scl_o, launch_stb, sample_stb;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    mon_on = 1'b0;
    logic  prev_scl = 1'b1;
    bit    seen [4];
    ev_t   hd;
    ev_t   exp_q [$];
    string cur_tag = "reset";

    i2c_scl_timing #(.CW(CW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .div_val    (div_val),
        .dly_cfg    (dly_cfg),
        .scl_o      (scl_o),
        .launch_stb (launch_stb),
        .sample_stb (sample_stb)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic string req_of(int k);
        case (k)
            K_FALL, K_RISE: return "R1";
            K_LAUNCH:       return "R4";
            default:        return "R5";
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, cur_tag, what, act, exp);
        end
    endtask

    // Monitor: compare observed edges and strobes against the queue head.
    always @(negedge clk) begin
        if (mon_on) begin
            seen[K_FALL]   = prev_scl && !scl_o;
            seen[K_RISE]   = !prev_scl && scl_o;
            seen[K_LAUNCH] = launch_stb;
            seen[K_SAMPLE] = sample_stb;
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                check(1'b0, req_of(exp_q[0].kind),
                      $sformatf("missing event kind %0d", exp_q[0].kind), cyc, exp_q[0].cyc);
                void'(exp_q.pop_front());
            end
            for (int k = 0; k < 4; k++) begin
                if (seen[k]) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9", $sformatf("unexpected event kind %0d at cycle", k), cyc, -1);
                    end else begin
                        hd = exp_q.pop_front();
                        check(hd.cyc == cyc && hd.kind == k, req_of(hd.kind),
                              $sformatf("event kind %0d (seen kind %0d) cycle", hd.kind, k), cyc, hd.cyc);
                    end
                end
            end
            prev_scl = scl_o;
        end
    end

    task automatic push_sorted(int c, int k);
        ev_t e;
        int  pos;
        e.cyc = c;
        e.kind = k;
        pos = exp_q.size();
        while (pos > 0 && (exp_q[pos-1].cyc * 4 + exp_q[pos-1].kind) > (c * 4 + k)) pos--;
        exp_q.insert(pos, e);
    endtask

    // Driver: program, predict n full periods, run, stop, and check the idle tail.
    task automatic run(int dv, int fd, int rd, int n, bit late, string tag);
        int h, fe, re, c0, stop_c, end_c, f;
        cur_tag = tag;
        h  = ((dv / 2) % 32768 == 0 && (dv / 2) == 0) ? 32768 : dv / 2;   // R3 for 0 and 1
        fe = (fd > h) ? h : fd;                                          // R6 clamp
        re = (rd > h) ? h : rd;
        @(negedge clk);
        div_val = dv[CW-1:0];
        dly_cfg = {fd[15:0], rd[15:0]};                                  // R7 field layout
        repeat (2) @(negedge clk);
        c0 = cyc + 1;                                                    // R8 first active cycle
        for (int j = 0; j < n; j++) begin
            f = c0 + (2 * j + 1) * h;
            push_sorted(f, K_FALL);
            push_sorted(f + h, K_RISE);
            push_sorted(f + fe, K_LAUNCH);
            push_sorted(f + h + re, K_SAMPLE);
        end
        enable = 1'b1;
        stop_c = late ? (c0 + 2 * n * h + h - 1) : (c0 + (2 * n - 1) * h);
        while (cyc != stop_c) @(negedge clk);
        enable = 1'b0;                                                   // R9 stop request
        end_c = c0 + (2 * n + 1) * h + 6;
        while (cyc < end_c) @(negedge clk);
        check(exp_q.size() == 0, "R9", "events still owed after stop", exp_q.size(), 0);
        check(scl_o === 1'b1, "R9", "scl rests high after stop", scl_o, 1);
        check(!launch_stb && !sample_stb, "R9", "strobes quiet after stop",
              {launch_stb, sample_stb}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(scl_o === 1'b1, "R8", "scl high during reset", scl_o, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(scl_o === 1'b1 && !launch_stb && !sample_stb, "R8", "idle outputs after reset",
                  {scl_o, launch_stb, sample_stb}, 4);
        end
        prev_scl = 1'b1;
        mon_on = 1'b1;
        run(8,  1,  2,  3, 1'b0, "R1 basic H=4");
        run(5,  0,  1,  3, 1'b1, "R2 odd divider, R4 zero launch delay");
        run(4,  0,  1,  2, 1'b0, "R2 even twin of divider 5");
        run(2,  1,  1,  4, 1'b0, "R10 minimum divider");
        run(2,  0,  7,  2, 1'b1, "R10 minimum divider, clamp");
        run(12, 20, 6,  2, 1'b0, "R6 launch delay clamped, R7 fields");
        run(20, 0,  10, 3, 1'b1, "R5 capture and launch in one cycle");
        run(14, 5,  0,  2, 1'b0, "R7 swapped-field detector");
        run(0,  3,  5,  1, 1'b0, "R3 zero divider largest period");
        mon_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog [%s]: actual %0d cycles expected fewer", cur_tag, cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule